// File: doc/BRIEF.md
# Tag-Scheduled Reservation Station Pool

This block holds a small pool of reservation stations together with a per-register producer tag table and the register values. It schedules instructions in dataflow order: an instruction leaves the pool as soon as both of its operands are known, whatever its place in program order. Results come back on a shared result bus. Each bus transfer carries a value and the tag of the station that produced it, not a register number.

At dispatch the instruction takes the lowest-numbered free station. Each source register is resolved in one of two ways. If the register has no pending producer, its value is copied into the station. Otherwise the station keeps the producer's tag. The destination register is then relabelled with the new station's tag, so a later reader waits on the newest producer only. A waiting station compares its tags against every bus transfer and captures a match. The register table accepts a bus value only while its tag still names that producer. Because of this, write-after-write and write-after-read cases never stall dispatch.

Dispatch and issue are valid/ready streams. Dispatch is accepted in a cycle when `disp_valid` and `disp_ready` are both high. `disp_ready` is low exactly when every station is occupied. Issue is accepted when `iss_valid` and `iss_ready` are both high. While `iss_ready` is low, the offered item may change to a lower-numbered station that has just become ready. The result bus has no back-pressure. At most one transfer arrives per cycle, and arbitration among completing units happens upstream.

Top module: `tag_rs_sched`

## Requirements
- R1: After reset every station is free, `disp_ready` is 1, `iss_valid` is 0, and every register reads tag 0 with value 0.
- R2: A dispatched instruction whose sources have tag 0 copies their register values and is offered on the issue port in the next cycle, with its opcode and station tag.
- R3: A source whose register carries a nonzero tag is held as that tag. The station is not offered until a bus transfer with that tag arrives, and it is offered in the cycle after that transfer with the bus value as the operand.
- R4: Station i (counting from 0) has tag i+1, and tag 0 means "value present in the register table". A dispatch sets the destination register's tag to the new station's tag from the next cycle.
- R5: A bus transfer writes a register's value and clears its tag only when the register's tag equals the bus tag. A transfer from an older producer of a register that has since been renamed leaves the value and the tag unchanged.
- R6: A bus transfer in the same cycle as a dispatch is forwarded into the new station when a source tag matches it.
- R7: When all stations are occupied, `disp_ready` is 0 and a `disp_valid` pulse has no effect.
- R8: When several stations are ready, the lowest-numbered one is offered. A station that has been accepted on the issue port is not offered again.
- R9: A station stays occupied after issue and becomes free in the cycle after the bus carries its tag. The next dispatch then takes the lowest-numbered free station.
- R10: When a dispatch renames a register in the same cycle that the bus completes that register's current producer, the new tag wins.
- R11: An instruction that reads and writes the same register uses the register's mapping from before its own rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A station is free |
| disp_op | input | OPW | Opcode of the dispatched instruction |
| disp_src_a | input | log2(NREG) | First source register |
| disp_src_b | input | log2(NREG) | Second source register |
| disp_dst | input | log2(NREG) | Destination register |
| bc_valid | input | 1 | Result bus transfer present |
| bc_tag | input | TAGW | Producer tag of the transfer (never 0) |
| bc_value | input | DW | Result value |
| iss_valid | output | 1 | A station with both operands is offered |
| iss_ready | input | 1 | Execution side accepts the offer |
| iss_op | output | OPW | Offered opcode |
| iss_a | output | DW | First operand value |
| iss_b | output | DW | Second operand value |
| iss_tag | output | TAGW | Tag of the offered station |
| rd_addr | input | log2(NREG) | Register table look-up address |
| rd_tag | output | TAGW | Producer tag of that register |
| rd_value | output | DW | Stored value of that register |

## Verification
A dispatch edge makes the destination tag visible, and the station's issue offer appear, one cycle later. A bus edge updates the register table and the capturing stations one cycle later, so a station waiting on it is offered in the cycle after the transfer. A station freed by the bus can be taken by a dispatch in the following cycle. The bench drives inputs just after a rising edge and samples everything at the next falling edge, so each result is read in exactly the cycle it is due. The monitor pops an expected issue item each time the offer is accepted, and it counts any accepted offer that has no expected item as a miscompare.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_SENT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_select.sv
module rs_select #(
  parameter int NRS = 4,
  localparam int IW = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NRS-1:0] busy,
  input  logic [NRS-1:0] ready,
  output logic           free_any,
  output logic [IW-1:0]  free_idx,
  output logic           grant_any,
  output logic [IW-1:0]  grant_idx,
  output logic [NRS-1:0] grant
);
  always_comb begin
    free_any  = 1'b0;
    free_idx  = '0;
    grant_any = 1'b0;
    grant_idx = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
      if (ready[i]) begin
        grant_any = 1'b1;
        grant_idx = IW'(i);
      end
    end
    grant = grant_any ? (NRS'(1) << grant_idx) : '0;
  end

  // R8: at most one station is offered, and it is the lowest ready one
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |-> ((ready & (grant - NRS'(1))) == '0));
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TAGW = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_fire,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  input  logic [RW-1:0]   dst,
  input  logic [TAGW-1:0] new_tag,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DW-1:0]   bc_value,
  output logic [TAGW-1:0] a_tag,
  output logic [DW-1:0]   a_val,
  output logic [TAGW-1:0] b_tag,
  output logic [DW-1:0]   b_val,
  input  logic [RW-1:0]   rd_addr,
  output logic [TAGW-1:0] rd_tag,
  output logic [DW-1:0]   rd_value
);
  logic [TAGW-1:0] qi  [NREG];
  logic [DW-1:0]   val [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic newest_done;
    logic renamed;
    assign newest_done = bc_valid && (bc_tag != '0) && (qi[r] == bc_tag);
    assign renamed     = disp_fire && (dst == RW'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        qi[r]  <= '0;
        val[r] <= '0;
      end else begin
        if (newest_done) val[r] <= bc_value;
        if (renamed)          qi[r] <= new_tag;
        else if (newest_done) qi[r] <= '0;
      end
    end

    // R5: only the producer named by the tag may update the register
    p_newest_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && bc_tag != '0 && qi[r] == bc_tag && !renamed)
        |=> (qi[r] == '0 && val[r] == $past(bc_value)));
    p_stale_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && qi[r] != bc_tag && !renamed)
        |=> (val[r] == $past(val[r]) && qi[r] == $past(qi[r])));
  end

  assign a_tag    = qi[src_a];
  assign a_val    = val[src_a];
  assign b_tag    = qi[src_b];
  assign b_val    = val[src_b];
  assign rd_tag   = qi[rd_addr];
  assign rd_value = val[rd_addr];

  // R4, R10: a rename lands even when the same register completes
  p_rename_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (qi[$past(dst)] == $past(new_tag)));
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int OPW = 6,
  parameter int DW  = 16,
  parameter int TAGW = 4,
  parameter logic [TAGW-1:0] MY_TAG = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [OPW-1:0]  load_op,
  input  logic [TAGW-1:0] load_qj,
  input  logic [DW-1:0]   load_vj,
  input  logic [TAGW-1:0] load_qk,
  input  logic [DW-1:0]   load_vk,
  input  logic            sent,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DW-1:0]   bc_value,
  output logic            busy,
  output logic            ready,
  output logic [OPW-1:0]  op,
  output logic [DW-1:0]   vj,
  output logic [DW-1:0]   vk
);
  slot_state_e     state;
  logic [TAGW-1:0] qj, qk;
  logic            hit_j, hit_k, done;

  assign hit_j = bc_valid && (qj != '0) && (bc_tag == qj);
  assign hit_k = bc_valid && (qk != '0) && (bc_tag == qk);
  assign done  = bc_valid && (bc_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_IDLE;
      op    <= '0;
      qj    <= '0;
      qk    <= '0;
      vj    <= '0;
      vk    <= '0;
    end else if (load) begin
      state <= SLOT_PEND;
      op    <= load_op;
      qj    <= load_qj;
      vj    <= load_vj;
      qk    <= load_qk;
      vk    <= load_vk;
    end else begin
      if (state != SLOT_IDLE && done) state <= SLOT_IDLE;
      else if (sent)                  state <= SLOT_SENT;
      if (state == SLOT_PEND && hit_j) begin
        qj <= '0;
        vj <= bc_value;
      end
      if (state == SLOT_PEND && hit_k) begin
        qk <= '0;
        vk <= bc_value;
      end
    end
  end

  assign busy  = (state != SLOT_IDLE);
  assign ready = (state == SLOT_PEND) && (qj == '0) && (qk == '0);

  // R3: a matching transfer is captured into the waiting operand
  p_capture_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLOT_PEND && hit_j) |=> (qj == '0 && vj == $past(bc_value)));
  p_capture_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLOT_PEND && hit_k) |=> (qk == '0 && vk == $past(bc_value)));
  // R9: own tag on the bus frees the station
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  // R8: once accepted, the station is no longer offered
  p_sent_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && !done) |=> !ready);
endmodule

// File: rtl/tag_rs_sched.sv
module tag_rs_sched #(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int OPW  = 6,
  parameter int DW   = 16,
  parameter int TAGW = 4,
  localparam int RW = $clog2(NREG),
  localparam int IW = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  output logic            disp_ready,
  input  logic [OPW-1:0]  disp_op,
  input  logic [RW-1:0]   disp_src_a,
  input  logic [RW-1:0]   disp_src_b,
  input  logic [RW-1:0]   disp_dst,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [DW-1:0]   bc_value,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [OPW-1:0]  iss_op,
  output logic [DW-1:0]   iss_a,
  output logic [DW-1:0]   iss_b,
  output logic [TAGW-1:0] iss_tag,
  input  logic [RW-1:0]   rd_addr,
  output logic [TAGW-1:0] rd_tag,
  output logic [DW-1:0]   rd_value
);
  logic [NRS-1:0] busy, ready, grant;
  logic           free_any, grant_any, disp_fire, iss_fire;
  logic [IW-1:0]  free_idx, grant_idx;
  logic [TAGW-1:0] new_tag;
  logic [TAGW-1:0] a_tag, b_tag, fq_a, fq_b;
  logic [DW-1:0]   a_val, b_val, fv_a, fv_b;
  logic [OPW-1:0]  st_op [NRS];
  logic [DW-1:0]   st_vj [NRS];
  logic [DW-1:0]   st_vk [NRS];

  assign disp_ready = free_any;
  assign disp_fire  = disp_valid && free_any;
  assign iss_valid  = grant_any;
  assign iss_fire   = grant_any && iss_ready;
  assign new_tag    = TAGW'(free_idx) + TAGW'(1);

  rs_select #(.NRS(NRS)) u_select (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready),
    .free_any(free_any), .free_idx(free_idx),
    .grant_any(grant_any), .grant_idx(grant_idx), .grant(grant)
  );

  rs_regstat #(.NREG(NREG), .DW(DW), .TAGW(TAGW)) u_regstat (
    .clk(clk), .rst_n(rst_n), .disp_fire(disp_fire),
    .src_a(disp_src_a), .src_b(disp_src_b), .dst(disp_dst), .new_tag(new_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .a_tag(a_tag), .a_val(a_val), .b_tag(b_tag), .b_val(b_val),
    .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_value(rd_value)
  );

  // Operand resolution with same-cycle forwarding from the result bus
  always_comb begin
    fq_a = a_tag;
    fv_a = a_val;
    if (a_tag != '0) begin
      fv_a = '0;
      if (bc_valid && bc_tag == a_tag) begin
        fq_a = '0;
        fv_a = bc_value;
      end
    end
    fq_b = b_tag;
    fv_b = b_val;
    if (b_tag != '0) begin
      fv_b = '0;
      if (bc_valid && bc_tag == b_tag) begin
        fq_b = '0;
        fv_b = bc_value;
      end
    end
  end

  for (genvar i = 0; i < NRS; i++) begin : g_st
    rs_station #(.OPW(OPW), .DW(DW), .TAGW(TAGW), .MY_TAG(TAGW'(i + 1))) u_st (
      .clk(clk), .rst_n(rst_n),
      .load(disp_fire && free_idx == IW'(i)),
      .load_op(disp_op), .load_qj(fq_a), .load_vj(fv_a),
      .load_qk(fq_b), .load_vk(fv_b),
      .sent(iss_fire && grant[i]),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
      .busy(busy[i]), .ready(ready[i]),
      .op(st_op[i]), .vj(st_vj[i]), .vk(st_vk[i])
    );
  end

  assign iss_op  = st_op[grant_idx];
  assign iss_a   = st_vj[grant_idx];
  assign iss_b   = st_vk[grant_idx];
  assign iss_tag = TAGW'(grant_idx) + TAGW'(1);

  // R7: a full pool refuses dispatch
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !disp_ready);
  // R2: an accepted dispatch occupies a station next cycle
  p_disp_occupies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> busy[$past(free_idx)]);
  // R1: nothing is offered from an empty pool
  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '0) |-> !iss_valid);
endmodule

// File: tb/test_tag_rs_sched.sv
`timescale 1ns/10ps
module test_tag_rs_sched;
  localparam int OPW = 6, DW = 16, TAGW = 4, NREG = 8;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [DW-1:0]   a;
    logic [DW-1:0]   b;
    logic [TAGW-1:0] tag;
  } iss_item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [OPW-1:0] disp_op = '0;
  logic [2:0] disp_src_a = '0, disp_src_b = '0, disp_dst = '0;
  logic bc_valid = 1'b0;
  logic [TAGW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_value = '0;
  logic iss_valid, iss_ready = 1'b1;
  logic [OPW-1:0] iss_op;
  logic [DW-1:0] iss_a, iss_b;
  logic [TAGW-1:0] iss_tag;
  logic [2:0] rd_addr = '0;
  logic [TAGW-1:0] rd_tag;
  logic [DW-1:0] rd_value;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  iss_item_t expq[$];

  always #2 clk = ~clk;

  tag_rs_sched i_tag_rs_sched (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag),
    .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_value(rd_value)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected issue item when an offer is accepted (R2, R3, R6, R8)
  always @(negedge clk) begin
    if (rst_n && !done && iss_valid && iss_ready) begin
      iss_item_t got;
      got = '{op: iss_op, a: iss_a, b: iss_b, tag: iss_tag};
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected issue", 64'(got), 64'h0);
      end else begin
        iss_item_t e;
        e = expq.pop_front();
        check(got == e, "R2/R3/R6/R8 issue item", 64'(got), 64'(e));
      end
    end
  end

  task automatic expect_iss(input int op, input int a, input int b, input int tag);
    expq.push_back('{op: OPW'(op), a: DW'(a), b: DW'(b), tag: TAGW'(tag)});
  endtask

  task automatic step(input bit dv, input int op, input int sa, input int sb, input int d,
                      input bit bv, input int bt, input int bval);
    disp_valid = dv; disp_op = OPW'(op);
    disp_src_a = 3'(sa); disp_src_b = 3'(sb); disp_dst = 3'(d);
    bc_valid = bv; bc_tag = TAGW'(bt); bc_value = DW'(bval);
    @(posedge clk); #1;
    disp_valid = 1'b0; bc_valid = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bcast(input int t, input int v);
    step(0, 0, 0, 0, 0, 1, t, v);
  endtask

  task automatic disp(input int op, input int sa, input int sb, input int d);
    step(1, op, sa, sb, d, 0, 0, 0);
  endtask

  task automatic reg_chk(input int r, input int tag, input int v, input string req);
    rd_addr = 3'(r);
    #0.1;
    check(rd_tag == TAGW'(tag), req, 64'(rd_tag), 64'(tag));
    check(rd_value == DW'(v), req, 64'(rd_value), 64'(v));
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      check(1'b0, "watchdog", 64'h0, 64'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(disp_ready == 1'b1, "R1 disp_ready", 64'(disp_ready), 64'h1);
    check(iss_valid == 1'b0, "R1 iss_valid", 64'(iss_valid), 64'h0);
    for (int r = 0; r < NREG; r++) reg_chk(r, 0, 0, "R1 register");

    // R2, R4: ready sources, destination renamed to station 0 (tag 1)
    @(posedge clk); #1;
    expect_iss(1, 0, 0, 1);
    disp(1, 1, 2, 3);
    @(negedge clk); reg_chk(3, 1, 0, "R4 dst tag");
    idle();
    bcast(1, 16'h1111);
    @(negedge clk); reg_chk(3, 0, 16'h1111, "R5 newest write");

    // R3: dependent instruction waits for the bus
    @(posedge clk); #1;
    expect_iss(3, 0, 0, 1);
    disp(3, 1, 1, 4);
    idle();
    expect_iss(4, 16'h00AA, 16'h1111, 2);
    disp(4, 4, 3, 5);
    @(negedge clk);
    check(iss_valid == 1'b0, "R3 waiting not offered", 64'(iss_valid), 64'h0);
    @(posedge clk); #1;
    bcast(1, 16'h00AA);
    idle();
    bcast(2, 16'h0B0B);
    @(negedge clk); reg_chk(5, 0, 16'h0B0B, "R5 result written");

    // R6: same-cycle forwarding into the new station
    @(posedge clk); #1;
    expect_iss(6, 0, 0, 1);
    disp(6, 1, 1, 6);
    idle();
    expect_iss(7, 16'h0066, 16'h00AA, 2);
    step(1, 7, 6, 4, 7, 1, 1, 16'h0066);
    idle();
    bcast(2, 16'h0777);
    @(negedge clk); reg_chk(7, 0, 16'h0777, "R6 chain result");

    // R5: stale producer does not overwrite the renamed register
    @(posedge clk); #1;
    expect_iss(8, 0, 0, 1);
    disp(8, 0, 0, 2);
    idle();
    expect_iss(9, 0, 0, 2);
    disp(9, 0, 0, 2);
    idle();
    bcast(1, 16'hDEAD);
    @(negedge clk); reg_chk(2, 2, 0, "R5 stale ignored");
    @(posedge clk); #1;
    bcast(2, 16'hBEEF);
    @(negedge clk); reg_chk(2, 0, 16'hBEEF, "R5 newest write");

    // R10: rename wins over same-cycle completion
    @(posedge clk); #1;
    expect_iss(10, 0, 0, 1);
    disp(10, 0, 0, 3);
    idle();
    expect_iss(11, 0, 0, 2);
    step(1, 11, 0, 0, 3, 1, 1, 16'h3333);
    @(negedge clk); reg_chk(3, 2, 16'h3333, "R10 rename wins");
    @(posedge clk); #1;
    bcast(2, 16'h4444);

    // R11: self-dependent instruction uses the old mapping
    expect_iss(13, 0, 0, 1);
    disp(13, 0, 0, 3);
    idle();
    expect_iss(12, 16'h5555, 16'h5555, 2);
    disp(12, 3, 3, 3);
    @(negedge clk);
    check(iss_valid == 1'b0, "R11 waits on old producer", 64'(iss_valid), 64'h0);
    @(posedge clk); #1;
    bcast(1, 16'h5555);
    @(negedge clk); reg_chk(3, 2, 16'h4444, "R11 old producer no write");
    @(posedge clk); #1;
    idle();
    bcast(2, 16'h6666);

    // R7, R8, R9: fill the pool with issue held off
    iss_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expect_iss(20 + k, 16'h6666, 16'h0777, k + 1);
      disp(20 + k, 3, 7, 0);
    end
    @(negedge clk);
    check(disp_ready == 1'b0, "R7 full pool", 64'(disp_ready), 64'h0);
    check(iss_tag == 4'd1, "R8 lowest offered", 64'(iss_tag), 64'h1);
    @(posedge clk); #1;
    disp(30, 0, 0, 1);
    @(negedge clk); reg_chk(1, 0, 0, "R7 dispatch ignored");
    @(posedge clk); #1;
    iss_ready = 1'b1;
    repeat (4) idle();
    @(negedge clk);
    check(disp_ready == 1'b0, "R9 busy after issue", 64'(disp_ready), 64'h0);
    @(posedge clk); #1;
    bcast(3, 16'h0333);
    @(negedge clk);
    check(disp_ready == 1'b1, "R9 freed by bus", 64'(disp_ready), 64'h1);
    reg_chk(0, 4, 0, "R5 older tag ignored");
    @(posedge clk); #1;
    expect_iss(40, 16'h0777, 16'h0066, 3);
    disp(40, 7, 6, 1);
    @(negedge clk); reg_chk(1, 3, 0, "R9 reuse lowest free");
    @(posedge clk); #1;
    idle();
    bcast(1, 16'h0111);
    bcast(2, 16'h0222);
    bcast(4, 16'h0444);
    bcast(3, 16'h0A0A);
    @(negedge clk);
    reg_chk(0, 0, 16'h0444, "R5 last producer");
    reg_chk(1, 0, 16'h0A0A, "R9 reused station result");
    check(expq.size() == 0, "R8 all expected issued", 64'(expq.size()), 64'h0);
    check(disp_ready == 1'b1, "R9 pool drained", 64'(disp_ready), 64'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule